// File: doc/BRIEF.md
# Privilege-Aware Interrupt Priority Selector

This block keeps one sticky pending flag for each of seven interrupt sources and decides which of them a processor core should take next. Posting a source (by index) sets its flag. The choice depends on the core's current state: the hypervisor-privilege bit, the global interrupt-enable bit, the enable for the trap-level-zero event, the current trap level, the software-interrupt register and the processor interrupt level (PIL).

The selection is presented every cycle as a valid flag, a cause code and, for software interrupts, a level. When the core raises its take strobe while the valid flag is high, the serviced source's pending flag is cleared. The one exception is a software interrupt: its flag is cleared only when no other software levels remain set. A separate outstanding-post counter drives an any-pending output. A post with an out-of-range index is dropped and reported with a one-cycle error pulse.

Top module: `isel_top`

## Requirements
- R1: After synchronous reset, all pending flags and the post counter are zero, and `any_pend`, `sel_vld`, `post_err` and `sel_level` are all 0.
- R2: A post with index 0..6 sets that source's flag. The indices and cause codes are: 0 trap-level-zero, 1 hypervisor tick match, 2 interrupt vector, 3 CPU queue, 4 device queue, 5 resumable error, 6 software. Each accepted post increments the counter, even if the flag was already set. Each flag-clearing take decrements it. `any_pend` is high exactly while the counter is nonzero, and the counter saturates at its limits.
- R3: While `hpriv` is 1, nothing is selected unless `ie` is 1. When `ie` is 1, tick match (1) is chosen before interrupt vector (2), and no other source is considered.
- R4: While `hpriv` is 0, trap-level-zero (0) has top priority. It is selectable only when `tlz_en` is 1 and `trap_lvl` is 0.
- R5: While `hpriv` is 0, tick match (1) is selected next, whatever the value of `ie`.
- R6: While `hpriv` is 0 and `ie` is 1, the remaining sources are checked in this order: CPU queue (3), device queue (4), software (6), resumable error (5).
- R7: The software level is the index of the highest set bit among bits 15..1 of `soft_reg`, and 0 if none of them is set. If software is pending with a level below 6 and interrupt vector is pending, the interrupt vector (2) is selected in its place.
- R8: A software interrupt is selected only when its level is strictly greater than `pil`. Otherwise the search continues with resumable error. `sel_level` carries the level when the cause is 6 and is 0 otherwise.
- R9: `take` while `sel_vld` is high clears the selected flag. For cause 6, the flag is cleared only if no bit of 15..1 other than the serviced level is set in `soft_reg`.
- R10: A post with index 7 changes no flag and no count, and `post_err` is high for exactly the next cycle.
- R11: When a post and a clearing take hit the same source in one cycle, the flag stays set and the counter is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_vld | input | 1 | Post strobe |
| post_idx | input | 3 | Index of the posted source |
| take | input | 1 | Core takes the current selection |
| hpriv | input | 1 | Hypervisor-privilege mode |
| ie | input | 1 | Interrupt enable |
| tlz_en | input | 1 | Trap-level-zero event enable |
| trap_lvl | input | 3 | Current trap level |
| soft_reg | input | 16 | Software-interrupt register |
| pil | input | 4 | Processor interrupt level |
| any_pend | output | 1 | Post counter nonzero |
| sel_vld | output | 1 | A source is selected |
| sel_cause | output | 3 | Cause code of the selection |
| sel_level | output | 4 | Software level when cause is 6 |
| post_err | output | 1 | Out-of-range post seen last cycle |

## Verification
The assertions check invariants on every cycle. Nothing is selected in hypervisor mode without enable, and only causes 1 or 2 are selected there. A trap-level-zero selection always comes with its enable set and trap level 0. A software selection always lies above PIL. The error pulse follows bad posts exactly. Priority ordering between several pending sources, the conditional clearing of the software flag, and the counter running ahead of the flags after repeated posts are shown only by the bench's scenarios. The bench compares these against a reference model.

// File: rtl/isel_pkg.sv
package isel_pkg;
  localparam int NSRC  = 7;
  localparam int IDX_W = 3;

  typedef enum logic [IDX_W-1:0] {
    SRC_TLZERO = 3'd0,
    SRC_HTICK  = 3'd1,
    SRC_VEC    = 3'd2,
    SRC_CPUQ   = 3'd3,
    SRC_DEVQ   = 3'd4,
    SRC_RERR   = 3'd5,
    SRC_SOFT   = 3'd6
  } src_e;
endpackage

// File: rtl/isel_soft_level.sv
module isel_soft_level #(
  parameter int SW_W  = 16,
  parameter int LVL_W = $clog2(SW_W)
) (
  input  logic [SW_W-1:0]  soft_reg,
  output logic [LVL_W-1:0] lvl,
  output logic             rest_nz
);
  logic [SW_W-1:0] masked;
  logic [SW_W-1:0] top_oh;

  always_comb begin
    lvl    = '0;
    top_oh = '0;
    for (int i = 1; i < SW_W; i++) begin
      if (soft_reg[i]) begin
        lvl    = LVL_W'(i);
        top_oh = SW_W'(1) << i;
      end
    end
    masked  = soft_reg & ~(SW_W'(1));
    rest_nz = |(masked & ~top_oh);
  end
endmodule

// File: rtl/isel_pick.sv
module isel_pick
  import isel_pkg::*;
#(
  parameter int LVL_W = 4,
  parameter int VEC_LVL = 6
) (
  input  logic [NSRC-1:0]  pend,
  input  logic             hpriv,
  input  logic             ie,
  input  logic             tlz_ok,
  input  logic [LVL_W-1:0] lvl,
  input  logic [LVL_W-1:0] pil,
  input  logic             rest_nz,
  output logic             vld,
  output src_e             cause,
  output logic [LVL_W-1:0] level,
  output logic             clr
);
  localparam logic [LVL_W-1:0] VEC_LIM = LVL_W'(VEC_LVL);

  always_comb begin
    vld   = 1'b0;
    cause = SRC_TLZERO;
    level = '0;
    clr   = 1'b0;
    if (hpriv) begin
      if (ie && pend[SRC_HTICK]) begin
        vld = 1'b1; cause = SRC_HTICK; clr = 1'b1;
      end else if (ie && pend[SRC_VEC]) begin
        vld = 1'b1; cause = SRC_VEC; clr = 1'b1;
      end
    end else begin
      if (pend[SRC_TLZERO] && tlz_ok) begin
        vld = 1'b1; cause = SRC_TLZERO; clr = 1'b1;
      end else if (pend[SRC_HTICK]) begin
        vld = 1'b1; cause = SRC_HTICK; clr = 1'b1;
      end else if (ie) begin
        if (pend[SRC_CPUQ]) begin
          vld = 1'b1; cause = SRC_CPUQ; clr = 1'b1;
        end else if (pend[SRC_DEVQ]) begin
          vld = 1'b1; cause = SRC_DEVQ; clr = 1'b1;
        end else if (pend[SRC_SOFT] && lvl < VEC_LIM && pend[SRC_VEC]) begin
          vld = 1'b1; cause = SRC_VEC; clr = 1'b1;
        end else if (pend[SRC_SOFT] && lvl > pil) begin
          vld = 1'b1; cause = SRC_SOFT; level = lvl; clr = !rest_nz;
        end else if (pend[SRC_RERR]) begin
          vld = 1'b1; cause = SRC_RERR; clr = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/isel_pend_bank.sv
module isel_pend_bank
  import isel_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             post_vld,
  input  logic [IDX_W-1:0] post_idx,
  input  logic             take_clr,
  input  src_e             take_src,
  output logic [NSRC-1:0]  pend,
  output logic             any_pend,
  output logic             post_err
);
  localparam logic [IDX_W-1:0] IDX_LIM = IDX_W'(NSRC);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             post_ok, post_bad;

  assign post_ok  = post_vld && (post_idx < IDX_LIM);
  assign post_bad = post_vld && !(post_idx < IDX_LIM);
  assign any_pend = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= '0;
      cnt_q    <= '0;
      post_err <= 1'b0;
    end else begin
      post_err <= post_bad;
      for (int i = 0; i < NSRC; i++) begin
        if (post_ok && post_idx == IDX_W'(i))
          pend[i] <= 1'b1;
        else if (take_clr && take_src == src_e'(i))
          pend[i] <= 1'b0;
      end
      if (post_ok && !take_clr) begin
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end else if (!post_ok && take_clr) begin
        if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/isel_top.sv
module isel_top
  import isel_pkg::*;
#(
  parameter int SW_W  = 16,
  parameter int TL_W  = 3,
  parameter int CNT_W = 8,
  parameter int LVL_W = $clog2(SW_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             post_vld,
  input  logic [IDX_W-1:0] post_idx,
  input  logic             take,
  input  logic             hpriv,
  input  logic             ie,
  input  logic             tlz_en,
  input  logic [TL_W-1:0]  trap_lvl,
  input  logic [SW_W-1:0]  soft_reg,
  input  logic [LVL_W-1:0] pil,
  output logic             any_pend,
  output logic             sel_vld,
  output logic [IDX_W-1:0] sel_cause,
  output logic [LVL_W-1:0] sel_level,
  output logic             post_err
);
  logic [NSRC-1:0]  pend;
  logic [LVL_W-1:0] lvl;
  logic             rest_nz, clr;
  src_e             cause;

  isel_soft_level #(.SW_W(SW_W), .LVL_W(LVL_W)) u_lvl (
    .soft_reg(soft_reg), .lvl(lvl), .rest_nz(rest_nz)
  );

  isel_pick #(.LVL_W(LVL_W)) u_pick (
    .pend(pend), .hpriv(hpriv), .ie(ie),
    .tlz_ok(tlz_en && trap_lvl == '0),
    .lvl(lvl), .pil(pil), .rest_nz(rest_nz),
    .vld(sel_vld), .cause(cause), .level(sel_level), .clr(clr)
  );

  isel_pend_bank #(.CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst(rst), .post_vld(post_vld), .post_idx(post_idx),
    .take_clr(take && sel_vld && clr), .take_src(cause),
    .pend(pend), .any_pend(any_pend), .post_err(post_err)
  );

  assign sel_cause = cause;
endmodule

// File: rtl/isel_chk.sv
module isel_chk
  import isel_pkg::*;
#(
  parameter int TL_W  = 3,
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             post_vld,
  input logic [IDX_W-1:0] post_idx,
  input logic             hpriv,
  input logic             ie,
  input logic             tlz_en,
  input logic [TL_W-1:0]  trap_lvl,
  input logic [LVL_W-1:0] pil,
  input logic             sel_vld,
  input logic [IDX_W-1:0] sel_cause,
  input logic [LVL_W-1:0] sel_level,
  input logic             post_err
);
  AST_HPRIV_NEEDS_IE: assert property (@(posedge clk) disable iff (rst) (hpriv && !ie) |-> !sel_vld); // R3
  AST_HPRIV_CAUSES: assert property (@(posedge clk) disable iff (rst) (hpriv && sel_vld) |-> (sel_cause == 3'd1 || sel_cause == 3'd2)); // R3
  AST_TLZ_GATED: assert property (@(posedge clk) disable iff (rst) (sel_vld && sel_cause == 3'd0) |-> (tlz_en && trap_lvl == '0 && !hpriv)); // R4
  AST_SOFT_ABOVE_PIL: assert property (@(posedge clk) disable iff (rst) (sel_vld && sel_cause == 3'd6) |-> (sel_level > pil)); // R8
  AST_LEVEL_ZERO: assert property (@(posedge clk) disable iff (rst) !(sel_vld && sel_cause == 3'd6) |-> (sel_level == '0)); // R8
  AST_ERR_RISE: assert property (@(posedge clk) disable iff (rst) (post_vld && post_idx == 3'd7) |=> post_err); // R10
  AST_ERR_ONLY: assert property (@(posedge clk) disable iff (rst) !(post_vld && post_idx == 3'd7) |=> !post_err); // R10
endmodule

bind isel_top isel_chk #(.TL_W(TL_W), .LVL_W(LVL_W)) chk_i (
  .clk(clk), .rst(rst), .post_vld(post_vld), .post_idx(post_idx),
  .hpriv(hpriv), .ie(ie), .tlz_en(tlz_en), .trap_lvl(trap_lvl), .pil(pil),
  .sel_vld(sel_vld), .sel_cause(sel_cause), .sel_level(sel_level),
  .post_err(post_err)
);

// File: tb/isel_top_tb_top.sv
module isel_top_tb_top;
  logic clk = 0, rst = 1;
  logic post_vld = 0, take = 0, hpriv = 0, ie = 0, tlz_en = 0;
  logic [2:0] post_idx = 0, trap_lvl = 0;
  logic [15:0] soft_reg = 0;
  logic [3:0] pil = 0;
  logic any_pend, sel_vld, post_err;
  logic [2:0] sel_cause;
  logic [3:0] sel_level;

  int checks = 0, errors = 0;
  bit [6:0] m_pend = 0;
  int m_cnt = 0;
  bit m_err = 0;

  always #10 clk = ~clk;

  isel_top dut_i (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic void model(output bit v, output int c, output int l, output bit clr);
    int lv = 0;
    v = 0; c = 0; l = 0; clr = 0;
    for (int i = 1; i < 16; i++) if (soft_reg[i]) lv = i;
    if (hpriv) begin
      if (ie && m_pend[1]) begin v = 1; c = 1; clr = 1; end
      else if (ie && m_pend[2]) begin v = 1; c = 2; clr = 1; end
    end else if (m_pend[0] && tlz_en && trap_lvl == 0) begin v = 1; c = 0; clr = 1; end
    else if (m_pend[1]) begin v = 1; c = 1; clr = 1; end
    else if (ie) begin
      if (m_pend[3]) begin v = 1; c = 3; clr = 1; end
      else if (m_pend[4]) begin v = 1; c = 4; clr = 1; end
      else if (m_pend[6] && lv < 6 && m_pend[2]) begin v = 1; c = 2; clr = 1; end
      else if (m_pend[6] && lv > int'(pil)) begin
        v = 1; c = 6; l = lv;
        clr = ((soft_reg & ~16'h1 & ~(16'h1 << lv)) == 0);
      end
      else if (m_pend[5]) begin v = 1; c = 5; clr = 1; end
    end
  endfunction

  // drive at negedge, check, then apply model at the following posedge
  task automatic step(bit pv, int pi, bit tk, bit hp, bit e, bit tz, int tl, int sw, int pl);
    bit v, clr, ok, dec;
    int c, l;
    @(negedge clk);
    post_vld = pv; post_idx = 3'(pi); take = tk; hpriv = hp; ie = e;
    tlz_en = tz; trap_lvl = 3'(tl); soft_reg = 16'(sw); pil = 4'(pl);
    #1;
    model(v, c, l, clr);
    chk("R3-R8 sel_vld", int'(sel_vld), int'(v));
    if (v) chk("R3-R7 sel_cause", int'(sel_cause), c);
    chk("R8 sel_level", int'(sel_level), l);
    chk("R2 any_pend", int'(any_pend), int'(m_cnt != 0));
    chk("R10 post_err", int'(post_err), int'(m_err));
    @(posedge clk);
    ok  = pv && pi < 7;
    dec = tk && v && clr;
    m_err = pv && pi == 7;
    if (dec) m_pend[c] = 0;
    if (ok) m_pend[pi] = 1;
    if (ok && !dec && m_cnt < 255) m_cnt++;
    else if (!ok && dec && m_cnt > 0) m_cnt--;
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    // R1 reset state
    chk("R1 any_pend", int'(any_pend), 0);
    chk("R1 sel_vld", int'(sel_vld), 0);
    chk("R1 post_err", int'(post_err), 0);
    chk("R1 sel_level", int'(sel_level), 0);
    // R10 bad index then idle
    step(1, 7, 0, 0, 1, 1, 0, 0, 0);
    step(0, 0, 0, 0, 1, 1, 0, 0, 0);
    step(0, 0, 0, 0, 1, 1, 0, 0, 0);
    // R2 R6 R5 R4 priorities: post rerr, devq, cpuq, htick, tlz
    step(1, 5, 0, 0, 1, 1, 0, 0, 0);
    step(1, 4, 0, 0, 1, 1, 0, 0, 0);
    step(1, 3, 0, 0, 1, 1, 0, 0, 0);
    step(1, 1, 0, 0, 0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0, 1, 2, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0, 0, 0);
    // R4 take tlz; R5 htick with ie low; R11 post+take same source
    step(0, 0, 1, 0, 0, 1, 0, 0, 0);
    step(1, 1, 1, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 1, 0, 0, 0, 0);
    // R7 R8 R9 software: level 9 with level 3 remaining keeps flag
    step(1, 6, 0, 0, 1, 0, 0, 16'h0208, 2);
    step(1, 2, 0, 0, 1, 0, 0, 16'h0208, 9);
    step(0, 0, 1, 0, 1, 0, 0, 16'h0208, 2);
    step(0, 0, 0, 0, 1, 0, 0, 16'h0008, 2);
    step(0, 0, 1, 0, 1, 0, 0, 16'h0008, 2);
    step(0, 0, 1, 0, 1, 0, 0, 16'h0009, 2);
    step(0, 0, 1, 0, 1, 0, 0, 16'h0009, 2);
    // R3 hypervisor mode
    step(1, 2, 0, 1, 0, 1, 0, 0, 0);
    step(1, 1, 0, 1, 1, 1, 0, 0, 0);
    step(0, 0, 1, 1, 1, 1, 0, 0, 0);
    step(0, 0, 1, 1, 1, 1, 0, 0, 0);
    // random mix covering R2-R11
    for (int n = 0; n < 4000; n++) begin
      int sw;
      sw = ($urandom % 4 == 0) ? 0 : (($urandom % 2) ? (1 << ($urandom % 16)) : int'($urandom % 65536));
      step(($urandom % 3) == 0, int'($urandom % 8), ($urandom % 2) == 1,
           ($urandom % 4) == 0, ($urandom % 4) != 0, ($urandom % 2) == 1,
           ($urandom % 3 == 0) ? int'($urandom % 8) : 0, sw, int'($urandom % 16));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule